// File: doc/BRIEF.md
# UART interrupt priority resolver

This block produces the interrupt identification byte and the interrupt request line of a 16550-style serial port. Each clock it looks at five interrupt sources and picks the most urgent enabled one. The sources are line-status errors, a receive character timeout, received data at or above the FIFO trigger level, the transmit holding register going empty, and modem-status changes. The identification byte and the request line are registered, so they follow the inputs one clock later.

The block owns the 4-bit interrupt enable value and the sticky transmit-empty pending flag. It also handles the side effects of a register write to the enable value and of a read of the identification byte. FIFO storage, shift registers and baud timing stay outside the block. Their state arrives as plain input levels: data ready, error bits, FIFO level, trigger level, timeout pending, THRE and the modem delta bits.

The pending flag is kept by a two-state machine:
- THR_QUIET: no transmit-empty interrupt is pending.
- THR_ARMED: a transmit-empty interrupt is pending.

The machine has three transitions:
- Arm (THR_QUIET to THR_ARMED): the enable bit for the transmitter is written from 0 to 1, or THRE rises.
- Drop (THR_ARMED to THR_QUIET): THRE is low, or the transmitter enable bit is written from 1 to 0.
- Acknowledge (THR_ARMED to THR_QUIET): a read of the identification byte returns the transmit-empty code.

Top module: `uart_irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, the identification byte reads 0x01, the request line is low and no transmit-empty interrupt is pending.
- R2: The sources are ranked in this order, from most to least urgent:
  - line status, code 0x6;
  - character timeout, code 0xC;
  - received data, code 0x4;
  - transmit empty, code 0x2;
  - modem status, code 0x0.

  Code 0x1 means that nothing is pending.
- R3: The line-status source is active when enable bit 2 is set and any of `line_stat[4:1]` (overrun, parity, framing, break) is 1. The data-ready bit `line_stat[0]` does not count for this source.
- R4: The character-timeout source is active when `rx_timeout` is 1 and enable bit 0 (the receive enable) is set. With enable bit 0 clear, the timeout never produces code 0xC.
- R5: The received-data source requires enable bit 0 and `line_stat[0]`.
  - With `fifo_en` low, nothing more is needed.
  - With `fifo_en` high, `rx_level` must also be at or above `rx_trigger`.
- R6: The modem-status source is active when enable bit 3 is set and any bit of `msr_delta` is 1.
- R7: The identification byte is laid out as follows:
  - bits 3:0 hold the resolved code;
  - bits 5:4 are 0;
  - bits 7:6 are 11 when `fifo_en` is high and 00 otherwise.
- R8: `irq` is high exactly when bits 3:0 of `iir` differ from 0x1. Both outputs reflect the inputs and state sampled at the previous rising clock edge. An enable write therefore shows up in the outputs two clocks after it is presented.
- R9: A cycle with `iir_rd` high, while `iir[3:0]` reads 0x2, clears the transmit-empty pending flag.
- R10: An enable write handles the pending flag as follows:
  - A write that changes enable bit 1 from 0 to 1 while `thre` is 1 sets the flag.
  - A write that changes bit 1 from 1 to 0 clears the flag.
  - A write that leaves bit 1 unchanged does not affect the flag.
- R11: A rising edge of `thre` sets the pending flag, and the flag is held clear while `thre` is 0. Within one cycle, the causes rank as follows:
  - clearing through `thre` low or the bit-1 clear wins over arming;
  - arming wins over the read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_we | input | 1 | Write strobe for the interrupt enable value |
| ier_wdata | input | 4 | Enable value to write: bit0 receive, bit1 transmit empty, bit2 line status, bit3 modem |
| iir_rd | input | 1 | Read strobe for the identification byte |
| fifo_en | input | 1 | FIFO mode active |
| line_stat | input | 5 | bit0 data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break |
| rx_level | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| thre | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem status change bits |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default `CNT_W` of 5. This covers FIFO levels from empty up to a full count of 16. It drives the trigger levels 1, 4, 8 and 14, so both the level-equals-trigger and level-one-below cases are reached. A randomized phase lets enable writes, identification reads and `thre` edges fall in the same cycle. That reaches the precedence ranking between drop, arm and acknowledge in the pending machine.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_W     = 4;

    // source slots, slot 0 is the most urgent
    localparam int SLOT_LINE    = 0;
    localparam int SLOT_TIMEOUT = 1;
    localparam int SLOT_RXDATA  = 2;
    localparam int SLOT_TXEMPTY = 3;
    localparam int SLOT_MODEM   = 4;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    typedef enum logic {
        THR_QUIET = 1'b0,
        THR_ARMED = 1'b1
    } thr_state_e;

    function automatic iid_e slot_code(input int slot);
        iid_e c;
        case (slot)
            SLOT_LINE:    c = IID_LINE;
            SLOT_TIMEOUT: c = IID_TIMEOUT;
            SLOT_RXDATA:  c = IID_RXDATA;
            SLOT_TXEMPTY: c = IID_TXEMPTY;
            SLOT_MODEM:   c = IID_MODEM;
            default:      c = IID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [EN_W-1:0]    ier,
    input  logic               fifo_en,
    input  logic [4:0]         line_stat,
    input  logic [CNT_W-1:0]   rx_level,
    input  logic [CNT_W-1:0]   rx_trigger,
    input  logic               rx_timeout,
    input  logic               thr_armed,
    input  logic [3:0]         msr_delta,
    output logic [NUM_SRC-1:0] req
);

    logic any_error;
    logic level_ok;

    always_comb begin
        any_error = |line_stat[4:1];
        level_ok  = !fifo_en || (rx_level >= rx_trigger);

        req                = '0;
        req[SLOT_LINE]     = ier[EN_LINE]  && any_error;
        req[SLOT_TIMEOUT]  = ier[EN_RX]    && rx_timeout;
        req[SLOT_RXDATA]   = ier[EN_RX]    && line_stat[0] && level_ok;
        req[SLOT_TXEMPTY]  = ier[EN_TX]    && thr_armed;
        req[SLOT_MODEM]    = ier[EN_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output iid_e               code
);

    logic [NUM_SRC-1:0] grant;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_chain
            if (g == 0) begin : g_top
                assign grant[g] = req[g];
            end else begin : g_lower
                assign grant[g] = req[g] && !(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code = IID_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                code = slot_code(i);
            end
        end
    end

endmodule

// File: rtl/uart_irq_thr_fsm.sv
module uart_irq_thr_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thre,
    input  logic thre_prev,
    input  logic ier_tx_old,
    input  logic ier_we,
    input  logic ier_tx_new,
    input  logic ack,
    output logic armed
);

    thr_state_e state_q;
    thr_state_e state_d;
    logic       drop;
    logic       arm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= THR_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        drop    = !thre || (ier_we && ier_tx_old && !ier_tx_new);
        arm     = (ier_we && !ier_tx_old && ier_tx_new) || !thre_prev;
        state_d = state_q;
        unique case (state_q)
            THR_QUIET: begin
                if (!drop && arm) begin
                    state_d = THR_ARMED;
                end
            end
            THR_ARMED: begin
                if (drop || (ack && !arm)) begin
                    state_d = THR_QUIET;
                end
            end
        endcase
    end

    always_comb begin
        armed = (state_q == THR_ARMED);
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_we,
    input  logic [3:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             fifo_en,
    input  logic [4:0]       line_stat,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rx_timeout,
    input  logic             thre,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       iir,
    output logic             irq
);

    logic [EN_W-1:0]    ier_q;
    logic               thre_prev_q;
    logic               thr_armed;
    logic [NUM_SRC-1:0] req;
    iid_e               code;
    logic [7:0]         iir_q;
    logic               irq_q;
    logic               ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q       <= '0;
            thre_prev_q <= 1'b1;
        end else begin
            if (ier_we) begin
                ier_q <= ier_wdata;
            end
            thre_prev_q <= thre;
        end
    end

    always_comb begin
        ack = iir_rd && (iir_q[3:0] == IID_TXEMPTY);
    end

    uart_irq_thr_fsm u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .thre       (thre),
        .thre_prev  (thre_prev_q),
        .ier_tx_old (ier_q[EN_TX]),
        .ier_we     (ier_we),
        .ier_tx_new (ier_wdata[EN_TX]),
        .ack        (ack),
        .armed      (thr_armed)
    );

    uart_irq_sources #(.CNT_W(CNT_W)) u_src (
        .ier        (ier_q),
        .fifo_en    (fifo_en),
        .line_stat  (line_stat),
        .rx_level   (rx_level),
        .rx_trigger (rx_trigger),
        .rx_timeout (rx_timeout),
        .thr_armed  (thr_armed),
        .msr_delta  (msr_delta),
        .req        (req)
    );

    uart_irq_resolver u_res (
        .req  (req),
        .code (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iir_q <= {4'h0, IID_NONE};
            irq_q <= 1'b0;
        end else begin
            iir_q <= {fifo_en, fifo_en, 2'b00, code};
            irq_q <= (code != IID_NONE);
        end
    end

    assign iir = iir_q;
    assign irq = irq_q;

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_we,
    input logic       ier_wr_tx,
    input logic       iir_rd,
    input logic       fifo_en,
    input logic [4:0] line_stat,
    input logic       rx_timeout,
    input logic       thre,
    input logic [3:0] msr_delta,
    input logic [7:0] iir,
    input logic       irq,
    input logic [3:0] ier_q,
    input logic       thre_prev_q,
    input logic       thr_armed
);

    logic line_hit;
    assign line_hit = ier_q[2] && (|line_stat[4:1]);

    // R2 and R3: enabled line errors take the top slot
    p_line_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_hit |=> (iir[3:0] == 4'h6));

    p_timeout_over_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[0] && rx_timeout && !line_hit) |=> (iir[3:0] == 4'hC));

    p_timeout_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_q[0] |=> (iir[3:0] != 4'hC));

    p_rx_nofifo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[0] && line_stat[0] && !fifo_en && !rx_timeout && !line_hit)
        |=> (iir[3:0] == 4'h4));

    p_modem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[3] && (|msr_delta)) |=> (iir[3:0] != 4'h1));

    p_fifo_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iir[7:6] == {2{$past(fifo_en)}}));

    p_iir_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iir[5:4] == 2'b00);

    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir[3:0] != 4'h1));

    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && (iir[3:0] == 4'h2) && !ier_we && thre_prev_q) |=> !thr_armed);

    p_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && ier_wr_tx && !ier_q[1] && thre) |=> thr_armed);

    p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !thre |=> !thr_armed);

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_we      (ier_we),
    .ier_wr_tx   (ier_wdata[1]),
    .iir_rd      (iir_rd),
    .fifo_en     (fifo_en),
    .line_stat   (line_stat),
    .rx_timeout  (rx_timeout),
    .thre        (thre),
    .msr_delta   (msr_delta),
    .iir         (iir),
    .irq         (irq),
    .ier_q       (ier_q),
    .thre_prev_q (thre_prev_q),
    .thr_armed   (thr_armed)
);

// File: tb/test_uart_irq_arbiter.sv
`timescale 1ns/1ps
module test_uart_irq_arbiter;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_we = 1'b0;
    logic [3:0]       ier_wdata = '0;
    logic             iir_rd = 1'b0;
    logic             fifo_en = 1'b0;
    logic [4:0]       line_stat = '0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] rx_trigger = 5'd1;
    logic             rx_timeout = 1'b0;
    logic             thre = 1'b1;
    logic [3:0]       msr_delta = '0;
    logic [7:0]       iir;
    logic             irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    logic [3:0] m_ier = '0;
    bit         m_pend = 0;
    bit         m_thre_prev = 1;
    logic [7:0] m_iir = 8'h01;
    bit         m_irq = 0;

    always #4 clk = ~clk;

    uart_irq_arbiter #(.CNT_W(CNT_W)) i_uart_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .fifo_en(fifo_en), .line_stat(line_stat),
        .rx_level(rx_level), .rx_trigger(rx_trigger), .rx_timeout(rx_timeout),
        .thre(thre), .msr_delta(msr_delta), .iir(iir), .irq(irq)
    );

    function automatic logic [3:0] ref_id();
        if (m_ier[2] && line_stat[4:1] != 0) return 4'h6;
        if (m_ier[0] && rx_timeout) return 4'hC;
        if (m_ier[0] && line_stat[0] && (!fifo_en || rx_level >= rx_trigger)) return 4'h4;
        if (m_ier[1] && m_pend) return 4'h2;
        if (m_ier[3] && msr_delta != 0) return 4'h0;
        return 4'h1;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic [3:0] id;
        bit drop, arm, ack;
        if (!rst_n) begin
            m_ier = '0; m_pend = 0; m_thre_prev = 1; m_iir = 8'h01; m_irq = 0;
        end else begin
            id   = ref_id();
            drop = !thre || (ier_we && m_ier[1] && !ier_wdata[1]);
            arm  = (ier_we && !m_ier[1] && ier_wdata[1]) || !m_thre_prev;
            ack  = iir_rd && (m_iir[3:0] == 4'h2);
            if (drop) m_pend = 0;
            else if (arm) m_pend = 1;
            else if (ack) m_pend = 0;
            m_iir = {fifo_en, fifo_en, 2'b00, id};
            m_irq = (id != 4'h1);
            if (ier_we) m_ier = ier_wdata;
            m_thre_prev = thre;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 2;
            if (iir !== m_iir) begin
                errors++;
                $display("FAIL %s model iir actual %h expected %h at %0t", cur_req, iir, m_iir, $time);
            end
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R8 model irq actual %b expected %b at %0t", irq, m_irq, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_we = 1'b1; ier_wdata = v;
        @(negedge clk);
        ier_we = 1'b0;
    endtask

    task automatic rd_iir();
        iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] exp);
        checks++;
        if (iir !== exp || irq !== (exp[3:0] != 4'h1)) begin
            errors++;
            $display("FAIL %s iir/irq actual %h/%b expected %h/%b", tag, iir, irq, exp, exp[3:0] != 4'h1);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run did not end");
        finish_run();
    end

    initial begin : stim
        // R1: reset state
        step(3);
        chk("R1", 8'h01);
        rst_n = 1'b1;
        step(1);
        chk("R1", 8'h01);

        // R10: enabling transmit-empty while THRE is high arms it
        cur_req = "R10";
        wr_ier(4'h2); step(2);
        chk("R10", 8'h02);
        // R9: reading the identification byte acknowledges it
        cur_req = "R9";
        rd_iir(); step(2);
        chk("R9", 8'h01);
        cur_req = "R10";
        wr_ier(4'h0); step(2);
        wr_ier(4'h2); step(2);
        chk("R10", 8'h02);
        wr_ier(4'h0); step(2);
        chk("R10", 8'h01);

        // R11: THRE low drops, rising THRE arms
        cur_req = "R11";
        wr_ier(4'h2); step(2);
        rd_iir(); step(2);
        thre = 1'b0; step(2);
        chk("R11", 8'h01);
        thre = 1'b1; step(2);
        chk("R11", 8'h02);
        thre = 1'b0; step(2);
        chk("R11", 8'h01);
        thre = 1'b1; step(2);
        rd_iir(); step(2);
        chk("R11", 8'h01);

        // R6: modem deltas
        cur_req = "R6";
        wr_ier(4'h8); msr_delta = 4'h4; step(2);
        chk("R6", 8'h00);
        wr_ier(4'h0); step(2);
        chk("R6", 8'h01);
        msr_delta = 4'h0;

        // R5 / R7: received data with and without FIFO
        cur_req = "R5";
        wr_ier(4'h1); line_stat = 5'h01; step(2);
        chk("R5", 8'h04);
        fifo_en = 1'b1; rx_trigger = 5'd4; rx_level = 5'd3; step(2);
        chk("R5", 8'hC1);
        rx_level = 5'd4; step(2);
        chk("R7", 8'hC4);
        rx_level = 5'd16; rx_trigger = 5'd14; step(2);
        chk("R5", 8'hC4);

        // R4: timeout, gated by the receive enable
        cur_req = "R4";
        rx_timeout = 1'b1; step(2);
        chk("R4", 8'hCC);
        wr_ier(4'h0); step(2);
        chk("R4", 8'hC1);
        rx_timeout = 1'b0; line_stat = 5'h00; fifo_en = 1'b0; rx_level = '0; step(2);

        // R3: each error bit alone, data ready does not count
        cur_req = "R3";
        wr_ier(4'h4); line_stat = 5'h01; step(2);
        chk("R3", 8'h01);
        for (int b = 1; b < 5; b++) begin
            line_stat = 5'(1 << b); step(2);
            chk("R3", 8'h06);
        end
        line_stat = 5'h00; step(2);

        // R2: peel sources off one by one
        cur_req = "R2";
        wr_ier(4'hF);
        line_stat = 5'h03; rx_timeout = 1'b1; msr_delta = 4'h1; step(2);
        chk("R2", 8'h06);
        line_stat = 5'h01; step(2);
        chk("R2", 8'h0C);
        rx_timeout = 1'b0; step(2);
        chk("R2", 8'h04);
        line_stat = 5'h00; step(2);
        chk("R2", 8'h02);
        rd_iir(); step(2);
        chk("R2", 8'h00);
        msr_delta = 4'h0; step(2);
        chk("R2", 8'h01);

        // randomized phase, model compared every clock
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            ier_we    = ($urandom % 6) == 0;
            ier_wdata = 4'($urandom);
            iir_rd    = ($urandom % 3) == 0;
            fifo_en   = 1'($urandom);
            line_stat = (($urandom % 4) == 0) ? 5'($urandom) : {4'b0, 1'($urandom)};
            rx_level  = 5'($urandom % 17);
            case ($urandom % 4)
                0: rx_trigger = 5'd1;
                1: rx_trigger = 5'd4;
                2: rx_trigger = 5'd8;
                default: rx_trigger = 5'd14;
            endcase
            rx_timeout = ($urandom % 4) == 0;
            if (($urandom % 5) == 0) thre = ~thre;
            msr_delta = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            @(negedge clk);
        end
        ier_we = 1'b0; iir_rd = 1'b0;
        step(3);
        finish_run();
    end

endmodule